// File: doc/BRIEF.md
# Four-Channel Time-Division Nibble Link

This block carries four independent serial channels over one shared 4-bit line by giving each channel its own time slot. On the sending side every channel clocks its serial input into a private 4-bit shift register, one bit per clock. A 2-bit slot index picks which channel's register drives the shared line during the current clock.

On the receiving side the same slot index steers the line to one of four output registers. A one-hot decoder enables only that register. Each channel is therefore sampled once in every four clocks, and its output holds between samples. Both sides run on one clock and share one slot counter, so no framing or alignment is needed.

The reset `rst_n` is asynchronous and active-low. It is expected to be released synchronously to `clk` by the surrounding reset logic.

Top module: `tdm_link`

## Requirements
- R1: While `rst_n` is low, `slot` is 0, `line` is 0 and every nibble of `rx_data` is 0.
- R2: `slot` advances by one on each rising clock edge out of reset, and goes from 3 back to 0.
- R3: On every rising edge, each channel's shift register takes its serial input bit into bit 0. Bits 0..2 move up to bits 1..3, and the old bit 3 is dropped.
- R4: Within a clock, `line` equals the shift-register contents of the channel numbered `slot`.
- R5: On the rising edge that ends slot k, nibble k of `rx_data` (bits 4k+3..4k) loads the value `line` had during that slot. This gives one clock of latency.
- R6: On that edge, the nibbles of `rx_data` for the other three channels keep their values.
- R7: Four serial bits b1, b2, b3, b4 fed to one channel on consecutive clocks appear on the line as {b1,b2,b3,b4}, with b1 in bit 3. This holds when the last of those edges makes the channel's slot current.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for the sending and receiving sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 4 | Serial input bits, bit k for channel k |
| slot | output | 2 | Current slot index, which is the channel on the line |
| line | output | 4 | Shared line word for the current slot |
| rx_data | output | 16 | Received nibbles; bits 4k+3..4k belong to channel k |

## Verification
`slot` and `line` are due in the same clock as the state that produces them. The bench reads them half a period after each rising edge, once the edge's updates have settled. A serial bit driven before an edge reaches the shift register at that edge, so it shows on `line` in the first clock whose slot selects that channel. A received nibble is due one edge after its slot: the bench model copies the pre-edge line word into the channel's expected nibble at that same edge, then compares all four nibbles at the following falling edge. The reset values are checked while reset is held low, both before the first edge and after a reset asserted in the middle of a run.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  // Defaults shared by the link and its sub-blocks.
  localparam int unsigned CHAN_COUNT = 4;
  localparam int unsigned WORD_BITS  = 4;
endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
  parameter int unsigned NCH = tdm_pkg::CHAN_COUNT,
  localparam int unsigned SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] slot_q
);
  logic [SW-1:0] slot_d;

  // Next slot: step by one and wrap after the last channel.
  always_comb begin
    if (slot_q == SW'(NCH - 1)) slot_d = '0;
    else                        slot_d = SW'(slot_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end
endmodule

// File: rtl/tdm_tx_shifter.sv
module tdm_tx_shifter #(
  parameter int unsigned W = tdm_pkg::WORD_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  output logic [W-1:0] word_q
);
  logic [W-1:0] word_d;

  // The newest bit enters at bit 0 and older bits move toward the MSB.
  always_comb word_d = {word_q[W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end
endmodule

// File: rtl/tdm_rx_bank.sv
module tdm_rx_bank #(
  parameter int unsigned NCH = tdm_pkg::CHAN_COUNT,
  parameter int unsigned W   = tdm_pkg::WORD_BITS,
  localparam int unsigned SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    sel,
  input  logic [W-1:0]     din,
  output logic [NCH*W-1:0] dout
);
  logic [NCH-1:0] load_en;

  // One-hot load enable decoded from the slot index.
  always_comb begin
    load_en = '0;
    load_en[sel] = 1'b1;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_reg
    logic [W-1:0] q;
    logic [W-1:0] d;

    always_comb d = load_en[k] ? din : q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign dout[k*W +: W] = q;
  end
endmodule

// File: rtl/tdm_link.sv
module tdm_link #(
  parameter int unsigned NCH = tdm_pkg::CHAN_COUNT,
  parameter int unsigned W   = tdm_pkg::WORD_BITS,
  localparam int unsigned SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   ser_in,
  output logic [SW-1:0]    slot,
  output logic [W-1:0]     line,
  output logic [NCH*W-1:0] rx_data
);
  logic [SW-1:0]    slot_q;
  logic [NCH*W-1:0] tx_words;

  tdm_slot_counter #(.NCH(NCH)) u_slot (
    .clk    (clk),
    .rst_n  (rst_n),
    .slot_q (slot_q)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_tx
    tdm_tx_shifter #(.W(W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_in (ser_in[k]),
      .word_q (tx_words[k*W +: W])
    );
  end

  // Sending-side multiplexer: the slot picks one channel's word.
  always_comb begin
    line = '0;
    for (int k = 0; k < NCH; k++) begin
      if (slot_q == SW'(k)) line = tx_words[k*W +: W];
    end
  end

  tdm_rx_bank #(.NCH(NCH), .W(W)) u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (slot_q),
    .din   (line),
    .dout  (rx_data)
  );

  assign slot = slot_q;
endmodule

// File: rtl/tdm_link_chk.sv
module tdm_link_chk #(
  parameter int unsigned NCH = tdm_pkg::CHAN_COUNT,
  parameter int unsigned W   = tdm_pkg::WORD_BITS,
  localparam int unsigned SW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SW-1:0]    slot,
  input logic [W-1:0]     line,
  input logic [NCH*W-1:0] rx_data
);
  logic             vld;
  logic [SW-1:0]    p_slot;
  logic [W-1:0]     p_line;
  logic [NCH*W-1:0] p_rx;

  // Values from the previous clock, valid after one edge out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      p_slot <= '0;
      p_line <= '0;
      p_rx   <= '0;
    end else begin
      vld    <= 1'b1;
      p_slot <= slot;
      p_line <= line;
      p_rx   <= rx_data;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_zero_r1: assert (slot == '0 && line == '0 && rx_data == '0)
        else $error("R1 outputs not cleared under reset");
    end
  end

  p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (slot == ((p_slot == SW'(NCH - 1)) ? '0 : SW'(p_slot + 1'b1))));

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    p_rx_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && p_slot == SW'(k)) |-> (rx_data[k*W +: W] == p_line));
    p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && p_slot != SW'(k)) |-> (rx_data[k*W +: W] == p_rx[k*W +: W]));
  end
endmodule

bind tdm_link tdm_link_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .slot    (slot),
  .line    (line),
  .rx_data (rx_data)
);

// File: tb/tdm_link_tb.sv
`timescale 1ns/1ps
module tdm_link_tb;
  logic        clk;
  logic        rst_n;
  logic [3:0]  ser_in;
  logic [1:0]  slot;
  logic [3:0]  line;
  logic [15:0] rx_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [3:0] m_sh [4];
  logic [3:0] m_rx [4];
  logic [1:0] m_slot;

  tdm_link u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .ser_in  (ser_in),
    .slot    (slot),
    .line    (line),
    .rx_data (rx_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [3:0] shift_in(logic [3:0] w, logic b);
    return {w[2:0], b};
  endfunction

  function automatic logic [1:0] next_slot(logic [1:0] s);
    return (s == 2'd3) ? 2'd0 : s + 2'd1;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 4; k++) begin
      m_sh[k] = '0;
      m_rx[k] = '0;
    end
    m_slot = '0;
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2 slot"}, {14'd0, slot}, {14'd0, m_slot});
    chk({tag, " R3/R4 line"}, {12'd0, line}, {12'd0, m_sh[m_slot]});
    for (int k = 0; k < 4; k++)
      chk({tag, " R5/R6 rx nibble"}, {12'd0, rx_data[k*4 +: 4]}, {12'd0, m_rx[k]});
  endtask

  // Called at a falling edge: drive bits, pass one rising edge, check.
  task automatic step(logic [3:0] bits, string tag);
    ser_in = bits;
    @(posedge clk);
    m_rx[m_slot] = m_sh[m_slot];
    for (int k = 0; k < 4; k++) m_sh[k] = shift_in(m_sh[k], bits[k]);
    m_slot = next_slot(m_slot);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n  = 1'b0;
    ser_in = '0;
    model_clear();
    #5;
    chk("R1 slot at reset", {14'd0, slot}, 16'd0);
    chk("R1 line at reset", {12'd0, line}, 16'd0);
    chk("R1 rx at reset", rx_data, 16'd0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R7: feed 1,1,0,1 to channel 0 so its slot comes round as the last bit lands.
    for (int i = 0; i < 4; i++) step({3'b000, (i != 2)}, "R7 dir");
    chk("R7 bit order on line", {12'd0, line}, 16'h000d);
    step(4'h0, "R5 dir");
    chk("R5 channel 0 captured", {12'd0, rx_data[3:0]}, 16'h000d);

    // All-ones and alternating patterns.
    for (int i = 0; i < 8; i++) step(4'hf, "ones");
    for (int i = 0; i < 8; i++) step((i % 2) ? 4'ha : 4'h5, "alt");

    // Random stimulus.
    for (int i = 0; i < 300; i++) step(4'($urandom), "rand");

    // Reset asserted in the middle of a run.
    rst_n = 1'b0;
    #2;
    model_clear();
    chk("R1 slot mid-run reset", {14'd0, slot}, 16'd0);
    chk("R1 line mid-run reset", {12'd0, line}, 16'd0);
    chk("R1 rx mid-run reset", rx_data, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 40; i++) step(4'($urandom), "post");
    finish_run();
  end
endmodule